// File: doc/BRIEF.md
# Address-Range Clean-and-Invalidate Engine

This block is the maintenance engine of a coherence home agent. Software loads a 64-bit base address and a 64-bit span through 32-bit register halves. It then writes a control word that starts the operation. The engine covers the addressed bytes in 128-byte line granules, visiting them in ascending order. For each granule it presents the line address to an external responsibility lookup. That lookup answers with an acknowledge and a hit flag, and the hit flag means the line is both owned by this unit and currently cached. For every hit the engine emits a one-cycle writeback-invalidate pulse that carries the line address.

The enable bit of the control word also serves as the busy flag. It reads as 1 for the whole walk and is cleared by hardware when the walk ends. Lines that miss cost one lookup each and never cause an error. This lets software send the same range to every agent in the system and leave each one to skip the lines it does not hold.

Top module: `rcm_engine`

## Requirements
- R1: The control word is at offset 0x5004. Bit 0 is enable, bit 1 is range mode and bits 3:2 are the operation type. Writing it with bit 0 set while idle launches an operation. Bits 3:1 read back as last accepted, and a write with bit 0 clear only stores them.
- R2: The base register is at 0x5008 (bits 31:0) and 0x500C (bits 63:32). The span register is at 0x5010 (bits 31:0) and 0x5014 (bits 63:32). Each reads back exactly what was written, and all of them reset to 0.
- R3: Bit 0 of the control word reads 1 from the first read after a launch until the operation ends, then returns to 0 without any write. It resets to 0.
- R4: The span is the last-byte offset, so the covered bytes run from base to base+span inclusive. One lookup is made for each 128-byte granule, starting at the granule that holds the base byte and ending at the granule that holds the last byte, in ascending order. The lookup address is the granule base, with bits 6:0 equal to 0.
- R5: Only one lookup is outstanding at a time. `line_req` and `line_addr` stay unchanged until `line_ack` is seen, and at most one lookup is accepted per cycle.
- R6: A lookup accepted with `line_hit`=1 produces a `wbi_valid` pulse in the next cycle, with `wbi_addr` equal to that lookup address. A lookup accepted with `line_hit`=0 produces no pulse, and an all-miss range still completes.
- R7: Only operation type 1 (clean and invalidate) with range mode set performs a walk. Any other launch makes no lookups and shows busy for exactly one cycle.
- R8: A control write while busy is ignored entirely. It neither restarts nor alters the running walk, and it does not change the stored bits 3:1.
- R9: When base+span carries past 2^64, the walk stops at the top granule of the address space and never wraps to low addresses.
- R10: `reg_rdata` is registered and holds the addressed value in the cycle after `reg_rd`. Offsets with no register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| line_req | output | 1 | Lookup request for the current granule |
| line_addr | output | 64 | Granule base address under lookup |
| line_ack | input | 1 | Lookup answered this cycle |
| line_hit | input | 1 | Line owned and present, valid with line_ack |
| wbi_valid | output | 1 | Writeback-invalidate pulse |
| wbi_addr | output | 64 | Line address for the writeback-invalidate |

## Verification
The assertions assume that the lookup side answers only while `line_req` is high, and that `line_hit` is meaningful only together with `line_ack`. The bench's responder drives both signals at the falling edge, and only when the request is visible. It holds them low otherwise, and it withholds acknowledges for pseudo-random stretches to exercise the hold rule. Register strobes are one cycle wide and never overlap. The hit pattern stays fixed during each walk, so that the expected writeback list computed before the launch remains valid.

// File: rtl/rcm_pkg.sv
package rcm_pkg;
  localparam logic [15:0] OFF_CTRL    = 16'h5004;
  localparam logic [15:0] OFF_BASE_LO = 16'h5008;
  localparam logic [15:0] OFF_BASE_HI = 16'h500C;
  localparam logic [15:0] OFF_SPAN_LO = 16'h5010;
  localparam logic [15:0] OFF_SPAN_HI = 16'h5014;

  // operation type code that requests clean-and-invalidate
  localparam logic [1:0] OP_CLEAN_INV = 2'd1;

  typedef enum logic [1:0] {W_IDLE, W_SEEK, W_FIN} walk_state_e;
endpackage

// File: rtl/rcm_csr.sv
module rcm_csr
  import rcm_pkg::*;
#(
  parameter int REG_AW = 16,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              busy,
  output logic [31:0]       reg_rdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] span_q,
  output logic              launch,
  output logic              walk_en
);
  localparam int HI_W = ADDR_W - 32;

  logic [2:0]  mode_q;   // {type[1:0], range}
  logic        sel_ctrl;
  logic [31:0] rd_mux;

  assign sel_ctrl = (reg_addr == REG_AW'(OFF_CTRL));
  assign launch   = reg_wr && sel_ctrl && reg_wdata[0] && !busy;
  assign walk_en  = reg_wdata[1] && (reg_wdata[3:2] == OP_CLEAN_INV);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      span_q <= '0;
      mode_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == REG_AW'(OFF_BASE_LO)) base_q[31:0]       <= reg_wdata;
      if (reg_addr == REG_AW'(OFF_BASE_HI)) base_q[ADDR_W-1:32] <= reg_wdata[HI_W-1:0];
      if (reg_addr == REG_AW'(OFF_SPAN_LO)) span_q[31:0]       <= reg_wdata;
      if (reg_addr == REG_AW'(OFF_SPAN_HI)) span_q[ADDR_W-1:32] <= reg_wdata[HI_W-1:0];
      if (sel_ctrl && !busy)                mode_q              <= reg_wdata[3:1];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == REG_AW'(OFF_CTRL))    rd_mux = {28'd0, mode_q, busy};
    if (reg_addr == REG_AW'(OFF_BASE_LO)) rd_mux = base_q[31:0];
    if (reg_addr == REG_AW'(OFF_BASE_HI)) rd_mux = 32'(base_q[ADDR_W-1:32]);
    if (reg_addr == REG_AW'(OFF_SPAN_LO)) rd_mux = span_q[31:0];
    if (reg_addr == REG_AW'(OFF_SPAN_HI)) rd_mux = 32'(span_q[ADDR_W-1:32]);
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R8: stored mode bits never move while an operation runs
  a_r8_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(mode_q));
endmodule

// File: rtl/rcm_walker.sv
module rcm_walker
  import rcm_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int GRAN_LG = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              walk_en,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] last_off,
  input  logic              line_ack,
  input  logic              line_hit,
  output logic              line_req,
  output logic [ADDR_W-1:0] line_addr,
  output logic              wbi_valid,
  output logic [ADDR_W-1:0] wbi_addr,
  output logic              busy
);
  localparam int IDX_W = ADDR_W - GRAN_LG;

  walk_state_e      st;
  logic [IDX_W-1:0] cur_idx, end_idx, first_idx, last_idx;
  logic [ADDR_W:0]  sum;
  logic             at_end;
  logic             unused_low;

  always_comb begin
    sum       = {1'b0, base_addr} + {1'b0, last_off};
    first_idx = base_addr[ADDR_W-1:GRAN_LG];
    // a carry out of the top bit clamps the walk at the last granule
    last_idx  = sum[ADDR_W] ? '1 : sum[ADDR_W-1:GRAN_LG];
  end
  assign unused_low = ^{sum[GRAN_LG-1:0], base_addr[GRAN_LG-1:0]};

  assign at_end    = (cur_idx == end_idx);
  assign line_addr = {cur_idx, {GRAN_LG{1'b0}}};
  assign busy      = (st != W_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= W_IDLE;
      line_req  <= 1'b0;
      cur_idx   <= '0;
      end_idx   <= '0;
      wbi_valid <= 1'b0;
      wbi_addr  <= '0;
    end else begin
      wbi_valid <= 1'b0;
      case (st)
        W_IDLE: if (launch) begin
          if (walk_en) begin
            st       <= W_SEEK;
            line_req <= 1'b1;
            cur_idx  <= first_idx;
            end_idx  <= last_idx;
          end else begin
            st <= W_FIN;
          end
        end
        W_SEEK: if (line_ack) begin
          wbi_valid <= line_hit;
          wbi_addr  <= line_addr;
          if (at_end) begin
            st       <= W_IDLE;
            line_req <= 1'b0;
          end else begin
            cur_idx <= cur_idx + 1'b1;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R5: an unanswered request holds its address
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    line_req && !line_ack |=> line_req && $stable(line_addr));
  // R6: a writeback pulse always follows an accepted hit
  a_r6_cause: assert property (@(posedge clk) disable iff (rst)
    wbi_valid |-> $past(line_req && line_ack && line_hit));
  // R3: no request is visible outside an operation
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !line_req);
  // R9: the walk pointer never passes its end granule
  a_r9_bound: assert property (@(posedge clk) disable iff (rst)
    line_req |-> cur_idx <= end_idx);
  // R4, R8: consecutive requests only move upward
  a_r4_ascend: assert property (@(posedge clk) disable iff (rst)
    line_req && $past(line_req) |-> line_addr >= $past(line_addr));
endmodule

// File: rtl/rcm_engine.sv
module rcm_engine
  import rcm_pkg::*;
#(
  parameter int REG_AW  = 16,
  parameter int ADDR_W  = 64,
  parameter int GRAN_LG = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              line_req,
  output logic [ADDR_W-1:0] line_addr,
  input  logic              line_ack,
  input  logic              line_hit,
  output logic              wbi_valid,
  output logic [ADDR_W-1:0] wbi_addr
);
  logic              busy, launch, walk_en;
  logic [ADDR_W-1:0] base_q, span_q;

  rcm_csr #(.REG_AW(REG_AW), .ADDR_W(ADDR_W)) u_csr (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .busy(busy),
    .reg_rdata(reg_rdata), .base_q(base_q), .span_q(span_q),
    .launch(launch), .walk_en(walk_en)
  );

  rcm_walker #(.ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG)) u_walk (
    .clk(clk), .rst(rst), .launch(launch), .walk_en(walk_en),
    .base_addr(base_q), .last_off(span_q),
    .line_ack(line_ack), .line_hit(line_hit),
    .line_req(line_req), .line_addr(line_addr),
    .wbi_valid(wbi_valid), .wbi_addr(wbi_addr), .busy(busy)
  );

  // R1: busy only rises after an enabling control write
  a_r1_launch: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_wr && reg_addr == REG_AW'(OFF_CTRL) && reg_wdata[0]));
endmodule

// File: tb/sim_rcm_engine.sv
module sim_rcm_engine;
  import rcm_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        line_req, line_ack = 1'b0, line_hit = 1'b0;
  logic [63:0] line_addr, wbi_addr;
  logic        wbi_valid;

  always #4 clk = ~clk;

  rcm_engine u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .line_req(line_req), .line_addr(line_addr),
    .line_ack(line_ack), .line_hit(line_hit),
    .wbi_valid(wbi_valid), .wbi_addr(wbi_addr)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;
  int hit_mode = 2;
  bit ack_en = 1'b1;
  logic [7:0] lfsr = 8'h5A;
  logic [63:0] exp_look[$];
  logic [63:0] exp_wbi[$];

  function automatic logic hit_of(logic [63:0] a);
    if (hit_mode == 0) return 1'b0;
    if (hit_mode == 1) return 1'b1;
    return a[7] ^ a[9] ^ a[12];
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks are entered at a falling edge and leave at one
  task automatic wr(logic [15:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // responder and scoreboard monitor
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    line_ack = 1'b0;
    line_hit = 1'b0;
    if (!rst && wbi_valid) begin
      if (exp_wbi.size() == 0) chk(1'b0, "R6 unexpected writeback", wbi_addr, 64'h0);
      else begin
        logic [63:0] e;
        e = exp_wbi.pop_front();
        chk(wbi_addr == e, "R6 writeback address", wbi_addr, e);
      end
    end
    if (!rst && line_req && ack_en && lfsr[1:0] != 2'b00) begin
      line_ack = 1'b1;
      line_hit = hit_of(line_addr);
      if (exp_look.size() == 0) chk(1'b0, "R4 unexpected lookup", line_addr, 64'h0);
      else begin
        logic [63:0] e;
        e = exp_look.pop_front();
        chk(line_addr == e, "R4 lookup address", line_addr, e);
      end
    end
  end

  task automatic expect_walk(logic [63:0] base, logic [63:0] span);
    logic [63:0] bg, lg, n;
    logic [64:0] s;
    bg = base >> 7;
    s  = {1'b0, base} + {1'b0, span};
    lg = s[64] ? {7'd0, {57{1'b1}}} : {7'd0, s[63:7]};
    n  = lg - bg + 64'd1;
    for (longint unsigned k = 0; k < n; k++) begin
      logic [63:0] a;
      a = (bg + k) << 7;
      exp_look.push_back(a);
      if (hit_of(a)) exp_wbi.push_back(a);
    end
  endtask

  task automatic wait_idle(output logic [31:0] v);
    for (int i = 0; i < 4000; i++) begin
      rd(OFF_CTRL, v);
      if (!v[0]) break;
    end
    chk(v[0] == 1'b0, "R3 enable self-clears", 64'(v[0]), 64'h0);
    repeat (2) @(negedge clk);
    chk(exp_look.size() == 0, "R4 every granule looked up", 64'(exp_look.size()), 64'h0);
    chk(exp_wbi.size() == 0, "R6 every hit written back", 64'(exp_wbi.size()), 64'h0);
  endtask

  task automatic run_op(logic [63:0] base, logic [63:0] span, logic [3:0] ctl);
    logic [31:0] v;
    wr(OFF_BASE_LO, base[31:0]);
    wr(OFF_BASE_HI, base[63:32]);
    wr(OFF_SPAN_LO, span[31:0]);
    wr(OFF_SPAN_HI, span[63:32]);
    if (ctl[0] && ctl[1] && ctl[3:2] == 2'd1) expect_walk(base, span);
    wr(OFF_CTRL, {28'd0, ctl});
    rd(OFF_CTRL, v);
    chk(v[0] == 1'b1, "R3 busy visible after launch", 64'(v[0]), 64'h1);
    wait_idle(v);
    chk(v[3:0] == {ctl[3:1], 1'b0}, "R1 control fields read back", 64'(v[3:0]), 64'({ctl[3:1], 1'b0}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state R2, R3
    rd(OFF_CTRL, v);    chk(v == 32'h0, "R3 control resets to 0", 64'(v), 64'h0);
    rd(OFF_BASE_LO, v); chk(v == 32'h0, "R2 base low reset", 64'(v), 64'h0);
    rd(OFF_BASE_HI, v); chk(v == 32'h0, "R2 base high reset", 64'(v), 64'h0);
    rd(OFF_SPAN_LO, v); chk(v == 32'h0, "R2 span low reset", 64'(v), 64'h0);
    rd(OFF_SPAN_HI, v); chk(v == 32'h0, "R2 span high reset", 64'(v), 64'h0);
    chk(line_req == 1'b0, "R3 no request after reset", 64'(line_req), 64'h0);

    // R2 readback
    wr(OFF_BASE_LO, 32'hDEAD_BEEF); wr(OFF_BASE_HI, 32'h1234_5678);
    wr(OFF_SPAN_LO, 32'hA5A5_0F0F); wr(OFF_SPAN_HI, 32'h8000_0001);
    rd(OFF_BASE_LO, v); chk(v == 32'hDEAD_BEEF, "R2 base low readback", 64'(v), 64'hDEAD_BEEF);
    rd(OFF_BASE_HI, v); chk(v == 32'h1234_5678, "R2 base high readback", 64'(v), 64'h1234_5678);
    rd(OFF_SPAN_LO, v); chk(v == 32'hA5A5_0F0F, "R2 span low readback", 64'(v), 64'hA5A5_0F0F);
    rd(OFF_SPAN_HI, v); chk(v == 32'h8000_0001, "R2 span high readback", 64'(v), 64'h8000_0001);
    // R10 unmapped offset
    rd(16'h5000, v); chk(v == 32'h0, "R10 unmapped offset reads 0", 64'(v), 64'h0);
    rd(16'h5018, v); chk(v == 32'h0, "R10 unmapped offset reads 0", 64'(v), 64'h0);

    // R1 store without launch
    wr(OFF_CTRL, 32'h6);
    rd(OFF_CTRL, v); chk(v == 32'h6, "R1 write without enable stores only", 64'(v), 64'h6);
    chk(line_req == 1'b0, "R1 no launch without enable", 64'(line_req), 64'h0);

    // R4 unaligned start spanning three granules, patterned hits
    hit_mode = 2; run_op(64'h0000_0000_1000_0040, 64'hFF, 4'h7);
    // R4 single byte, R6 all hits
    hit_mode = 1; run_op(64'h0000_0002_0000_0085, 64'h0, 4'h7);
    // R6 all miss still completes
    hit_mode = 0; run_op(64'h0000_0000_0003_0010, 64'h3FF, 4'h7);
    // R4 aligned exact granule
    hit_mode = 1; run_op(64'h0000_0000_0000_0100, 64'h7F, 4'h7);
    // R4 span crossing 32-bit boundary
    hit_mode = 2; run_op(64'h0000_0000_FFFF_FF80, 64'h2FF, 4'h7);
    // R9 carry past top of address space
    hit_mode = 1; run_op(64'hFFFF_FFFF_FFFF_FF10, 64'h1000, 4'h7);
    // R7 other type, and range clear
    run_op(64'h0000_0000_0000_4000, 64'h17F, 4'hB);
    run_op(64'h0000_0000_0000_4000, 64'h17F, 4'h5);

    // R5 and R8: stalled walk, control write while busy
    hit_mode = 2;
    ack_en = 1'b0;
    wr(OFF_BASE_LO, 32'h4000); wr(OFF_BASE_HI, 32'h0);
    wr(OFF_SPAN_LO, 32'h17F);  wr(OFF_SPAN_HI, 32'h0);
    expect_walk(64'h4000, 64'h17F);
    wr(OFF_CTRL, 32'h7);
    repeat (3) @(negedge clk);
    chk(line_req == 1'b1 && line_addr == 64'h4000, "R5 request held without ack", line_addr, 64'h4000);
    wr(OFF_CTRL, 32'h9);
    repeat (2) @(negedge clk);
    chk(line_addr == 64'h4000, "R8 busy control write ignored", line_addr, 64'h4000);
    ack_en = 1'b1;
    wait_idle(v);
    chk(v[3:0] == 4'h6, "R8 mode bits unchanged by ignored write", 64'(v[3:0]), 64'h6);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule